// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `OP_W` bits each. It spends one clock per multiplier bit. A pulse on `start_i` while the unit is idle captures both operands. The multiplicand is kept in a register one bit wider than the operand. A single working register holds the running partial product in its upper half and the multiplier in its lower half. That register carries one guard bit above the partial product and one recoding bit below the multiplier. The recoding bit is cleared at load.

Each step inspects the lowest two bits of the working register. It then adds the multiplicand, subtracts it, or leaves the upper half alone, and shifts the whole register one place right with sign fill. After `OP_W` steps the guard and recoding bits are dropped. The remaining `2*OP_W` bits form the signed product, which is announced by a one-cycle `done_o`.

A parameter chooses how the add/subtract is built: either one adder fed with an inverted operand and a carry-in, or separate adder and subtractor followed by a select.

Top module: `booth_seq_mul`

## Requirements
- R1: While `rst_n` is low and until the first accepted start, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A start is accepted only when `start_i` is 1 at a rising edge where `busy_o` is 0. `busy_o` is 1 from the following cycle.
- R3: After a start accepted at edge k, `busy_o` stays 1 for exactly `OP_W` cycles and falls at edge k+`OP_W`, and `done_o` is 1 in the cycle after that edge. `busy_o` never falls without `done_o`.
- R4: `done_o` is high for exactly one cycle, and `busy_o` is 0 whenever `done_o` is 1.
- R5: When `done_o` is 1, `product_o` read as signed equals the exact two's-complement product of the captured operands. This includes the most negative value times itself, zero, and -1.
- R6: A `start_i` pulse or any change of operand inputs while `busy_o` is 1 has no effect on the result or on the timing of the run in progress.
- R7: While idle and with no accepted start, `product_o` keeps the last finished product (or 0 after reset).
- R8: Recoding rule, with the pair formed by the lowest multiplier bit (upper) and the recoding bit (lower): 01 adds the sign-extended multiplicand to the guard-extended upper half, 10 subtracts it, and 00 and 11 leave it unchanged. The register then shifts right arithmetically. Both settings of `SHARED_ADDER` give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a multiplication |
| multiplicand_i | input | OP_W | Signed multiplicand, sampled on an accepted start |
| multiplier_i | input | OP_W | Signed multiplier, sampled on an accepted start |
| busy_o | output | 1 | A multiplication is in progress |
| done_o | output | 1 | One-cycle pulse: product_o holds the finished result |
| product_o | output | 2*OP_W | Signed product, valid with done_o and held while idle |

## Verification
The bench builds two copies of the block.

The first uses `OP_W = 8` with the shared adder. It takes the extreme operand pairs and several hundred random pairs, and it issues junk start pulses on busy cycles.

The second uses `OP_W = 5` with the split add/subtract path. It sweeps all 1024 operand pairs, so every recoding sequence and every overflow-prone corner of the guard bit is reached for that width.

Together the two builds exercise both generate variants against the same cycle-level model.

// File: rtl/booth_pkg.sv
package booth_pkg;
   // Action chosen from the two lowest bits of the working register.
   typedef enum logic [1:0] {
      BOOTH_HOLD = 2'b00,
      BOOTH_ADD  = 2'b01,
      BOOTH_SUB  = 2'b10
   } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic [1:0] pair_i,
   output booth_op_e  op_o
);
   // R8: 01 -> add, 10 -> subtract, 00/11 -> no change
   always_comb begin
      unique case (pair_i)
         2'b01:   op_o = BOOTH_ADD;
         2'b10:   op_o = BOOTH_SUB;
         default: op_o = BOOTH_HOLD;
      endcase
   end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int WIDTH        = 9,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  booth_op_e        op_i,
   output logic [WIDTH-1:0] sum_o
);
   generate
      if (SHARED_ADDER) begin : g_shared
         logic [WIDTH-1:0] operand;
         logic [WIDTH-1:0] carry_in;
         always_comb begin
            unique case (op_i)
               BOOTH_ADD: operand = mcand_i;
               BOOTH_SUB: operand = ~mcand_i;
               default:   operand = '0;
            endcase
            carry_in = {{(WIDTH-1){1'b0}}, (op_i == BOOTH_SUB)};
            sum_o    = acc_i + operand + carry_in;
         end
      end else begin : g_split
         logic [WIDTH-1:0] plus;
         logic [WIDTH-1:0] minus;
         always_comb begin
            plus  = acc_i + mcand_i;
            minus = acc_i - mcand_i;
            unique case (op_i)
               BOOTH_ADD: sum_o = plus;
               BOOTH_SUB: sum_o = minus;
               default:   sum_o = acc_i;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int STEPS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(STEPS + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;
   logic             last_step;

   assign load_o    = start_i && !busy_q;
   assign step_o    = busy_q;
   assign last_step = (cnt_q == CNT_W'(STEPS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_step) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end else if (load_o) begin
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_pkg::*;
#(
   parameter int OP_W         = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [OP_W-1:0]     multiplicand_i,
   input  logic [OP_W-1:0]     multiplier_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [2*OP_W-1:0]   product_o
);
   localparam int HALF_W = OP_W + 1;      // guard bit + upper half
   localparam int WORK_W = 2 * OP_W + 2;  // guard + product + recoding bit

   generate
      if (OP_W < 2 || OP_W > 30) begin : g_bad_width
         $error("booth_seq_mul: OP_W must lie in 2..30");
      end
   endgenerate

   logic              load;
   logic              step;
   logic [HALF_W-1:0] mcand_q;
   logic [WORK_W-1:0] work_q;
   logic [HALF_W-1:0] upper;
   logic [HALF_W-1:0] sum;
   booth_op_e         op;

   booth_ctrl #(.STEPS(OP_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .step_o  (step),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_recode u_recode (
      .pair_i (work_q[1:0]),
      .op_o   (op)
   );

   assign upper = work_q[WORK_W-1:OP_W+1];

   booth_addsub #(.WIDTH(HALF_W), .SHARED_ADDER(SHARED_ADDER)) u_addsub (
      .acc_i   (upper),
      .mcand_i (mcand_q),
      .op_i    (op),
      .sum_o   (sum)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand_q <= '0;
         work_q  <= '0;
      end else if (step) begin
         // arithmetic right shift of the updated register
         work_q <= {sum[HALF_W-1], sum, work_q[OP_W:1]};
      end else if (load) begin
         mcand_q <= {multiplicand_i[OP_W-1], multiplicand_i};
         work_q  <= {{HALF_W{1'b0}}, multiplier_i, 1'b0};
      end
   end

   assign product_o = work_q[2*OP_W:1];
endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int OP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [OP_W-1:0]   multiplicand_i,
   input logic [OP_W-1:0]   multiplier_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [2*OP_W-1:0] product_o
);
   logic [OP_W-1:0]          cap_a;
   logic [OP_W-1:0]          cap_b;
   logic [15:0]              run_cnt;
   logic signed [2*OP_W-1:0] exp_prod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_a   <= '0;
         cap_b   <= '0;
         run_cnt <= '0;
      end else if (start_i && !busy_o) begin
         cap_a   <= multiplicand_i;
         cap_b   <= multiplier_i;
         run_cnt <= '0;
      end else if (busy_o) begin
         run_cnt <= run_cnt + 16'd1;
      end
   end

   assign exp_prod = $signed({{OP_W{cap_a[OP_W-1]}}, cap_a})
                   * $signed({{OP_W{cap_b[OP_W-1]}}, cap_b});

   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_cnt == 16'(OP_W)));

   assert_busy_ends_in_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R6 also rests here: operands are captured only on an accepted start
   assert_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($signed(product_o) == exp_prod));

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.OP_W(OP_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .start_i        (start_i),
   .multiplicand_i (multiplicand_i),
   .multiplier_i   (multiplier_i),
   .busy_o         (busy_o),
   .done_o         (done_o),
   .product_o      (product_o)
);

// File: tb/booth_seq_mul_lane.sv
module booth_seq_mul_lane #(
   parameter int W          = 8,
   parameter bit SHARED     = 1'b1,
   parameter bit EXHAUSTIVE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_fail,
   output logic fin
);
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MAXV = ~MINV;
   localparam logic [W-1:0] NEG1 = '1;

   logic           start;
   logic [W-1:0]   a;
   logic [W-1:0]   b;
   logic           busy;
   logic           done;
   logic [2*W-1:0] prod;
   bit             junk_run;

   booth_seq_mul #(.OP_W(W), .SHARED_ADDER(SHARED)) u_booth_seq_mul (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start),
      .multiplicand_i (a),
      .multiplier_i   (b),
      .busy_o         (busy),
      .done_o         (done),
      .product_o      (prod)
   );

   // behavioural cycle model
   bit             m_busy;
   bit             m_done;
   int             m_cnt;
   logic [2*W-1:0] m_prod;
   logic [W-1:0]   m_a;
   logic [W-1:0]   m_b;

   function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y);
      longint sx;
      longint sy;
      longint p;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      p  = sx * sy;
      return p[2*W-1:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_cnt = 0; m_prod = '0; m_a = '0; m_b = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_cnt++;
            if (m_cnt == W) begin
               m_busy = 0;
               m_done = 1;
               m_prod = ref_mul(m_a, m_b);
            end
         end else if (start) begin
            m_busy = 1; m_cnt = 0; m_a = a; m_b = b;
         end
      end
   end

   initial begin n_chk = 0; n_fail = 0; end

   task automatic note(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s W=%0d %s actual=%0h expected=%0h", req, W, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      string tb_tag;
      string td_tag;
      string tp_tag;
      tb_tag = !rst_n ? "R1" : "R2/R3";
      td_tag = !rst_n ? "R1" : "R4";
      tp_tag = !rst_n ? "R1" : (m_done ? (junk_run ? "R6" : "R5/R8") : "R7");
      note(busy === m_busy, tb_tag, "busy", 64'(busy), 64'(m_busy));
      note(done === m_done, td_tag, "done", 64'(done), 64'(m_done));
      if (!m_busy)
         note(prod === m_prod, tp_tag, "product", 64'(prod), 64'(m_prod));
   end

   task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit junk);
      junk_run = junk;
      start = 1'b1; a = x; b = y;
      @(negedge clk);
      // R6: junk starts and moving operands while busy
      for (int k = 0; k < W; k++) begin
         start = junk;
         a = W'($urandom);
         b = W'($urandom);
         @(negedge clk);
      end
      start = 1'b0; a = W'($urandom); b = W'($urandom);
      @(negedge clk);  // idle cycle: R7 hold
   endtask

   initial begin
      start = 1'b0; a = '0; b = '0; fin = 1'b0; junk_run = 0;
      @(posedge rst_n);
      repeat (2) @(negedge clk);
      if (EXHAUSTIVE) begin
         for (int i = 0; i < (1 << W); i++)
            for (int j = 0; j < (1 << W); j++)
               run_op(W'(i), W'(j), ((i + j) % 3) == 0);
      end else begin
         run_op(MINV, MINV, 0);   // R5 most negative squared
         run_op(MINV, MAXV, 1);
         run_op(MAXV, MAXV, 0);
         run_op('0, MINV, 0);     // R5 zero
         run_op(MAXV, '0, 1);
         run_op(NEG1, NEG1, 0);   // R5 minus one
         run_op(NEG1, MINV, 0);
         run_op(MINV, NEG1, 1);
         run_op(W'(1), MINV, 0);
         run_op(W'(5), W'(3), 0);
         for (int r = 0; r < 400; r++)
            run_op(W'($urandom), W'($urandom), r[0]);
      end
      repeat (3) @(negedge clk);
      fin = 1'b1;
   end
endmodule

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   chk8, fail8, chk5, fail5;
   logic fin8, fin5;

   always #(CLK_PERIOD / 2) clk = ~clk;

   booth_seq_mul_lane #(.W(8), .SHARED(1'b1), .EXHAUSTIVE(1'b0)) u_lane_w8 (
      .clk (clk), .rst_n (rst_n), .n_chk (chk8), .n_fail (fail8), .fin (fin8)
   );

   booth_seq_mul_lane #(.W(5), .SHARED(1'b0), .EXHAUSTIVE(1'b1)) u_lane_w5 (
      .clk (clk), .rst_n (rst_n), .n_chk (chk5), .n_fail (fail5), .fin (fin5)
   );

   initial begin
      int cyc;
      int total;
      int bad;
      cyc = 0;
      bad = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      while (!(fin8 === 1'b1 && fin5 === 1'b1) && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      total = chk8 + chk5;
      bad   = fail8 + fail5;
      if (cyc >= WATCHDOG) begin
         total++;
         bad++;
         $display("FAIL R3 watchdog expired actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", total, bad);
      $finish;
   end
endmodule